// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block brings an Ethernet PHY into service after reset with no processor involved. It issues a fixed series of management register reads and writes through a request/acknowledge port that feeds an MDIO master elsewhere on the chip. Each request carries the PHY address, the register address, a write flag and write data. The sequence has these steps:

- Reset the PHY and wait for the reset to finish.
- Take the PHY out of isolation if it came up isolated.
- Record a baseline of the vendor status-output register.
- Program the PHY interrupt mask.
- Restart auto-negotiation.
- Confirm the PHY can auto-negotiate.
- Wait a bounded number of polls for the negotiation acknowledge, restarting negotiation whenever a remote fault is seen.
- Check the link.
- Latch the detected speed and duplex.

A single start pulse launches the sequence. The outcome is shown on `done_o` or `fail_o`, which stay up until the next start. Waits between polls come from a parameterised cycle counter. Every poll that waits for a self-clearing bit is limited to a fixed number of reads, so a stuck PHY ends in failure rather than a hang.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset no request is raised, and `done_o`, `fail_o`, `speed_o`, `duplex_o` and `snapshot_o` are zero. A start pulse while idle, done or failed clears the results. The next cycle it raises a write of register 0 with data 0x8000.
- R2: `req_o` stays high with unchanged fields until the cycle in which `ack_i` is high. For a read, `rdata_i` is taken in that acknowledge cycle. `req_phy_o` always equals `PHY_ADDR`.
- R3: After the reset write, register 0 is read repeatedly until bit 15 reads zero. The port stays idle for exactly `WAIT_CYCLES` cycles before each of these reads.
- R4: The read that shows bit 15 clear is checked for bit 10 (isolate). If bit 10 is set, 0x0000 is written to register 0 and register 0 is polled until bit 10 is clear. If bit 10 is clear, the write is skipped.
- R5: Register `STSOUT_REG` (default 18) is read once, and its value appears on `snapshot_o`.
- R6: Register `MASK_REG` (default 19) is then written with `IRQ_MASK`.
- R7: Register 0 is written with 0x3300 (bits 13, 12, 9 and 8). Register 0 is then polled until bit 9 reads zero.
- R8: Register 1 is read. If bit 3 (negotiation ability) is clear, `fail_o` rises and no further request is made.
- R9: Register 1 is polled at most `ACK_TRIES` (default 6) times, with a wait before each poll. A read with bit 5 set ends the polling. A read with bit 5 clear and bit 4 (remote fault) set is followed by a write of 0x3300 to register 0. When the tries run out, the sequence moves on to the link check.
- R10: Register 1 is read once more. If bit 2 (link) is clear, `fail_o` rises.
- R11: Otherwise register `STSOUT_REG` is read. `speed_o` takes its bit `SPD_BIT` (default 7), `duplex_o` takes its bit `DPX_BIT` (default 6), and `done_o` rises.
- R12: A poll from R3, R4 or R7 that still sees its bit set on the `POLL_LIMIT`-th read raises `fail_o` and makes no further request.
- R13: `done_o` and `fail_o` are never both high. Each stays high, with results unchanged, until the next start. A start while the sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| req_o | output | 1 | Management access request |
| req_wr_o | output | 1 | 1 = write, 0 = read |
| req_phy_o | output | 5 | PHY address |
| req_reg_o | output | 5 | Register address |
| req_wdata_o | output | 16 | Write data |
| ack_i | input | 1 | Access complete; read data valid |
| rdata_i | input | 16 | Read data |
| done_o | output | 1 | Bring-up succeeded |
| fail_o | output | 1 | Bring-up failed |
| speed_o | output | 1 | Detected speed flag |
| duplex_o | output | 1 | Detected duplex flag |
| snapshot_o | output | 16 | Baseline status-output value |

## Verification
A wrong state in this sequencer shows up at the request port on the very next access. The wrong register, a wrong write word or a skipped step is caught when that transaction is compared. An error in the wait counter shows up as a changed idle gap before a poll. An error in the poll budget shows up as an extra or a missing read before `fail_o` rises or the sequence moves on. A corrupted result only becomes visible at the end, on `speed_o`, `duplex_o` or `snapshot_o` once `done_o` is high.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam logic [4:0] REG_CTRL = 5'd0;
    localparam logic [4:0] REG_STAT = 5'd1;

    localparam int CTL_RESET   = 15;
    localparam int CTL_SPEED   = 13;
    localparam int CTL_AN_EN   = 12;
    localparam int CTL_ISOLATE = 10;
    localparam int CTL_AN_RST  = 9;
    localparam int CTL_DUPLEX  = 8;

    localparam int STS_AN_DONE = 5;
    localparam int STS_RFAULT  = 4;
    localparam int STS_AN_ABLE = 3;
    localparam int STS_LINK    = 2;

    localparam logic [15:0] RESET_WORD = 16'(1) << CTL_RESET;
    localparam logic [15:0] AN_WORD    = (16'(1) << CTL_AN_EN) | (16'(1) << CTL_AN_RST)
                                       | (16'(1) << CTL_SPEED) | (16'(1) << CTL_DUPLEX);

    typedef enum logic [4:0] {
        S_IDLE, S_RST_WR, S_RST_WAIT, S_RST_RD,
        S_ISO_WR, S_ISO_WAIT, S_ISO_RD,
        S_SNAP_RD, S_MASK_WR,
        S_AN_WR, S_AN_WAIT, S_AN_RD,
        S_CAP_RD, S_ACK_WAIT, S_ACK_RD, S_RF_WR,
        S_LINK_RD, S_RES_RD, S_DONE, S_FAIL
    } seq_state_e;

    typedef struct packed {
        seq_state_e  st;
        logic [15:0] snap;
        logic        spd;
        logic        dpx;
    } seq_regs_t;

endpackage

// File: rtl/phy_seq_cnt.sv
module phy_seq_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (dec_i && (cnt_q != '0))
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_seq_pkg::*;
#(
    parameter logic [4:0]  PHY_ADDR    = 5'd0,
    parameter logic [4:0]  STSOUT_REG  = 5'd18,
    parameter logic [4:0]  MASK_REG    = 5'd19,
    parameter logic [15:0] IRQ_MASK    = 16'h00FE,
    parameter int          SPD_BIT     = 7,
    parameter int          DPX_BIT     = 6,
    parameter int          WAIT_CYCLES = 16,
    parameter int          POLL_LIMIT  = 8,
    parameter int          ACK_TRIES   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        req_o,
    output logic        req_wr_o,
    output logic [4:0]  req_phy_o,
    output logic [4:0]  req_reg_o,
    output logic [15:0] req_wdata_o,
    input  logic        ack_i,
    input  logic [15:0] rdata_i,
    output logic        done_o,
    output logic        fail_o,
    output logic        speed_o,
    output logic        duplex_o,
    output logic [15:0] snapshot_o
);
    localparam int WT_W   = $clog2(WAIT_CYCLES + 1);
    localparam int PMAX   = (POLL_LIMIT > ACK_TRIES) ? POLL_LIMIT : ACK_TRIES;
    localparam int PC_W   = $clog2(PMAX + 1);
    localparam logic [WT_W-1:0] WT_LOAD = WT_W'(WAIT_CYCLES - 1);

    seq_regs_t r_d, r_q;

    logic            wt_load, wt_dec, wt_zero;
    logic [WT_W-1:0] wt_cnt;
    logic            pc_load, pc_dec, pc_zero;
    logic [PC_W-1:0] pc_val, pc_cnt;
    logic            acc, poll_last;

    phy_seq_cnt #(.W(WT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load_i(wt_load), .val_i(WT_LOAD),
        .dec_i(wt_dec), .cnt_o(wt_cnt), .zero_o(wt_zero)
    );

    phy_seq_cnt #(.W(PC_W)) u_poll (
        .clk(clk), .rst_n(rst_n), .load_i(pc_load), .val_i(pc_val),
        .dec_i(pc_dec), .cnt_o(pc_cnt), .zero_o(pc_zero)
    );

    // request decode from the current step
    always_comb begin
        req_o       = 1'b1;
        req_wr_o    = 1'b0;
        req_reg_o   = REG_CTRL;
        req_wdata_o = '0;
        unique case (r_q.st)
            S_RST_WR:                   begin req_wr_o = 1'b1; req_wdata_o = RESET_WORD; end
            S_ISO_WR:                   req_wr_o = 1'b1;
            S_AN_WR, S_RF_WR:           begin req_wr_o = 1'b1; req_wdata_o = AN_WORD; end
            S_MASK_WR:                  begin req_wr_o = 1'b1; req_reg_o = MASK_REG; req_wdata_o = IRQ_MASK; end
            S_RST_RD, S_ISO_RD, S_AN_RD: ;
            S_SNAP_RD, S_RES_RD:        req_reg_o = STSOUT_REG;
            S_CAP_RD, S_ACK_RD, S_LINK_RD: req_reg_o = REG_STAT;
            default:                    req_o = 1'b0;
        endcase
    end

    assign req_phy_o = PHY_ADDR;
    assign acc       = req_o && ack_i;
    assign poll_last = (pc_cnt <= PC_W'(1));

    always_comb begin
        r_d     = r_q;
        wt_load = 1'b0;
        wt_dec  = 1'b0;
        pc_load = 1'b0;
        pc_val  = PC_W'(POLL_LIMIT);
        pc_dec  = 1'b0;
        unique case (r_q.st)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start_i) begin
                    r_d.st   = S_RST_WR;
                    r_d.snap = '0;
                    r_d.spd  = 1'b0;
                    r_d.dpx  = 1'b0;
                end
            end
            S_RST_WR: if (acc) begin r_d.st = S_RST_WAIT; wt_load = 1'b1; pc_load = 1'b1; end
            S_ISO_WR: if (acc) begin r_d.st = S_ISO_WAIT; wt_load = 1'b1; pc_load = 1'b1; end
            S_AN_WR:  if (acc) begin r_d.st = S_AN_WAIT;  wt_load = 1'b1; pc_load = 1'b1; end
            S_RST_WAIT: if (wt_zero) r_d.st = S_RST_RD;  else wt_dec = 1'b1;
            S_ISO_WAIT: if (wt_zero) r_d.st = S_ISO_RD;  else wt_dec = 1'b1;
            S_AN_WAIT:  if (wt_zero) r_d.st = S_AN_RD;   else wt_dec = 1'b1;
            S_ACK_WAIT: if (wt_zero) r_d.st = S_ACK_RD;  else wt_dec = 1'b1;
            S_RST_RD: if (acc) begin
                if (!rdata_i[CTL_RESET])
                    r_d.st = rdata_i[CTL_ISOLATE] ? S_ISO_WR : S_SNAP_RD;
                else if (poll_last)
                    r_d.st = S_FAIL;
                else begin r_d.st = S_RST_WAIT; wt_load = 1'b1; pc_dec = 1'b1; end
            end
            S_ISO_RD: if (acc) begin
                if (!rdata_i[CTL_ISOLATE])
                    r_d.st = S_SNAP_RD;
                else if (poll_last)
                    r_d.st = S_FAIL;
                else begin r_d.st = S_ISO_WAIT; wt_load = 1'b1; pc_dec = 1'b1; end
            end
            S_SNAP_RD: if (acc) begin r_d.snap = rdata_i; r_d.st = S_MASK_WR; end
            S_MASK_WR: if (acc) r_d.st = S_AN_WR;
            S_AN_RD: if (acc) begin
                if (!rdata_i[CTL_AN_RST])
                    r_d.st = S_CAP_RD;
                else if (poll_last)
                    r_d.st = S_FAIL;
                else begin r_d.st = S_AN_WAIT; wt_load = 1'b1; pc_dec = 1'b1; end
            end
            S_CAP_RD: if (acc) begin
                if (!rdata_i[STS_AN_ABLE])
                    r_d.st = S_FAIL;
                else begin
                    r_d.st  = S_ACK_WAIT;
                    wt_load = 1'b1;
                    pc_load = 1'b1;
                    pc_val  = PC_W'(ACK_TRIES);
                end
            end
            S_ACK_RD: if (acc) begin
                pc_dec = 1'b1;
                if (rdata_i[STS_AN_DONE])
                    r_d.st = S_LINK_RD;
                else if (rdata_i[STS_RFAULT])
                    r_d.st = S_RF_WR;
                else if (poll_last)
                    r_d.st = S_LINK_RD;
                else begin r_d.st = S_ACK_WAIT; wt_load = 1'b1; end
            end
            S_RF_WR: if (acc) begin
                if (pc_zero) r_d.st = S_LINK_RD;
                else begin r_d.st = S_ACK_WAIT; wt_load = 1'b1; end
            end
            S_LINK_RD: if (acc) r_d.st = rdata_i[STS_LINK] ? S_RES_RD : S_FAIL;
            S_RES_RD: if (acc) begin
                r_d.spd = rdata_i[SPD_BIT];
                r_d.dpx = rdata_i[DPX_BIT];
                r_d.st  = S_DONE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= S_IDLE;
            r_q.snap <= '0;
            r_q.spd  <= 1'b0;
            r_q.dpx  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o     = (r_q.st == S_DONE);
    assign fail_o     = (r_q.st == S_FAIL);
    assign speed_o    = r_q.spd;
    assign duplex_o   = r_q.dpx;
    assign snapshot_o = r_q.snap;

    logic unused_wt;
    assign unused_wt = ^wt_cnt;
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        req_o,
    input logic        req_wr_o,
    input logic [4:0]  req_reg_o,
    input logic [15:0] req_wdata_o,
    input logic        ack_i,
    input logic        done_o,
    input logic        fail_o,
    input logic        speed_o,
    input logic        duplex_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> req_o && $stable(req_wr_o) && $stable(req_reg_o) && $stable(req_wdata_o)); // R2

    AST_START_RESET_WR: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (done_o || fail_o) |=> req_o && req_wr_o && (req_reg_o == 5'd0) && (req_wdata_o == 16'h8000)); // R1

    AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> !req_o); // R8

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o)); // R13

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(speed_o) && $stable(duplex_o)); // R11

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o && !start_i |=> fail_o); // R12
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (.*);

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
    localparam logic [4:0]  PHY   = 5'd3;
    localparam logic [15:0] MASKV = 16'h00FE;
    localparam int          WAITC = 4;
    localparam int          PLIM  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ack_i = 1'b0;
    logic [15:0] rdata_i = '0;
    logic        req_o, req_wr_o, done_o, fail_o, speed_o, duplex_o;
    logic [4:0]  req_phy_o, req_reg_o;
    logic [15:0] req_wdata_o, snapshot_o;

    int checks = 0;
    int fails  = 0;
    int last_gap = 0;

    always #2.5 clk = ~clk;

    phy_bringup_seq #(
        .PHY_ADDR(PHY), .IRQ_MASK(MASKV), .WAIT_CYCLES(WAITC), .POLL_LIMIT(PLIM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .req_o(req_o), .req_wr_o(req_wr_o), .req_phy_o(req_phy_o),
        .req_reg_o(req_reg_o), .req_wdata_o(req_wdata_o),
        .ack_i(ack_i), .rdata_i(rdata_i),
        .done_o(done_o), .fail_o(fail_o), .speed_o(speed_o),
        .duplex_o(duplex_o), .snapshot_o(snapshot_o)
    );

    // entry: {write, reg, wdata, rdata}
    localparam logic [37:0] NOM [18] = '{
        {1'b1, 5'd0,  16'h8000, 16'h0000},
        {1'b0, 5'd0,  16'h0000, 16'h8000},
        {1'b0, 5'd0,  16'h0000, 16'h0400},
        {1'b1, 5'd0,  16'h0000, 16'h0000},
        {1'b0, 5'd0,  16'h0000, 16'h0400},
        {1'b0, 5'd0,  16'h0000, 16'h0000},
        {1'b0, 5'd18, 16'h0000, 16'hA5C3},
        {1'b1, 5'd19, MASKV,    16'h0000},
        {1'b1, 5'd0,  16'h3300, 16'h0000},
        {1'b0, 5'd0,  16'h0000, 16'h3300},
        {1'b0, 5'd0,  16'h0000, 16'h3100},
        {1'b0, 5'd1,  16'h0000, 16'h0008},
        {1'b0, 5'd1,  16'h0000, 16'h0018},
        {1'b1, 5'd0,  16'h3300, 16'h0000},
        {1'b0, 5'd1,  16'h0000, 16'h0008},
        {1'b0, 5'd1,  16'h0000, 16'h002C},
        {1'b0, 5'd1,  16'h0000, 16'h0004},
        {1'b0, 5'd18, 16'h0000, 16'h0080}
    };

    function automatic string tag_of(int i);
        if (i < 3)  return "R3";
        if (i < 6)  return "R4";
        if (i == 6) return "R5";
        if (i == 7) return "R6";
        if (i < 11) return "R7";
        if (i == 11) return "R8";
        if (i < 16) return "R9";
        if (i == 16) return "R10";
        return "R11";
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // wait for a request at a negedge, compare it, acknowledge it
    task automatic txn(input logic wr, input logic [4:0] rg, input logic [15:0] wd,
                       input logic [15:0] rd, input string tag);
        int gap = 0;
        while (!req_o && gap < 2000) begin
            gap++;
            @(negedge clk);
        end
        last_gap = gap;
        chk(req_o && req_wr_o == wr && req_reg_o == rg && (!wr || req_wdata_o == wd),
            tag, {req_o, req_wr_o, 9'd0, req_reg_o, req_wdata_o},
            {1'b1, wr, 9'd0, rg, wr ? wd : req_wdata_o});
        chk(req_phy_o == PHY, "R2", 32'(req_phy_o), 32'(PHY));
        ack_i   = 1'b1;
        rdata_i = rd;
        @(posedge clk);
        @(negedge clk);
        ack_i   = 1'b0;
        rdata_i = 16'hDEAD;
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            if (req_o) seen++;
            @(negedge clk);
        end
        chk(seen == 0, tag, 32'(seen), 32'd0);
    endtask

    // reset, isolate skip, snapshot, mask, restart and its poll, capability read
    task automatic prefix(input logic [15:0] snap, input logic [15:0] cap);
        pulse_start();
        txn(1'b1, 5'd0,  16'h8000, 16'h0000, "R1");
        txn(1'b0, 5'd0,  16'h0000, 16'h0000, "R3");
        txn(1'b0, 5'd18, 16'h0000, snap,     "R4");
        txn(1'b1, 5'd19, MASKV,    16'h0000, "R6");
        txn(1'b1, 5'd0,  16'h3300, 16'h0000, "R7");
        txn(1'b0, 5'd0,  16'h0000, 16'h0000, "R7");
        txn(1'b0, 5'd1,  16'h0000, cap,      "R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(!req_o && !done_o && !fail_o && !speed_o && !duplex_o && snapshot_o == 0,
            "R1", {req_o, done_o, fail_o, speed_o, duplex_o, 11'd0, snapshot_o}, 32'd0);
        rst_n = 1'b1;
        quiet(5, "R1");

        // nominal walk: isolate cleared, remote fault restart, ack
        pulse_start();
        for (int i = 0; i < 18; i++) begin
            txn(NOM[i][37], NOM[i][36:32], NOM[i][31:16], NOM[i][15:0], tag_of(i));
            if (i == 1) chk(last_gap == WAITC, "R3", 32'(last_gap), 32'(WAITC));
            if (i == 14) chk(last_gap == WAITC, "R9", 32'(last_gap), 32'(WAITC));
        end
        chk(done_o && !fail_o, "R11", {30'd0, done_o, fail_o}, 32'd2);
        chk(speed_o && !duplex_o, "R11", {30'd0, speed_o, duplex_o}, 32'd2);
        chk(snapshot_o == 16'hA5C3, "R5", 32'(snapshot_o), 32'hA5C3);
        quiet(20, "R13");
        chk(done_o && speed_o && snapshot_o == 16'hA5C3, "R13",
            {15'd0, done_o, speed_o, snapshot_o}, {15'd0, 2'b11, 16'hA5C3});

        // duplex-only result, start while running is ignored
        pulse_start();
        chk(!done_o && !speed_o && snapshot_o == 0, "R1",
            {14'd0, done_o, speed_o, snapshot_o}, 32'd0);
        txn(1'b1, 5'd0, 16'h8000, 16'h0000, "R1");
        pulse_start();
        txn(1'b0, 5'd0,  16'h0000, 16'h0000, "R13");
        txn(1'b0, 5'd18, 16'h0000, 16'h1234, "R4");
        txn(1'b1, 5'd19, MASKV,    16'h0000, "R6");
        txn(1'b1, 5'd0,  16'h3300, 16'h0000, "R7");
        txn(1'b0, 5'd0,  16'h0000, 16'h0000, "R7");
        txn(1'b0, 5'd1,  16'h0000, 16'h0008, "R8");
        txn(1'b0, 5'd1,  16'h0000, 16'h0024, "R9");
        txn(1'b0, 5'd1,  16'h0000, 16'h0004, "R10");
        txn(1'b0, 5'd18, 16'h0000, 16'h0040, "R11");
        chk(done_o && !speed_o && duplex_o && snapshot_o == 16'h1234, "R11",
            {13'd0, done_o, speed_o, duplex_o, snapshot_o}, {13'd0, 3'b101, 16'h1234});

        // no negotiation ability
        prefix(16'h0001, 16'h0000);
        chk(fail_o && !done_o, "R8", {30'd0, fail_o, done_o}, 32'd2);
        quiet(30, "R8");

        // acknowledge never seen: six polls, then link down
        prefix(16'h0002, 16'h0008);
        for (int k = 0; k < 6; k++) txn(1'b0, 5'd1, 16'h0000, 16'h0008, "R9");
        chk(!fail_o && !done_o, "R9", {30'd0, fail_o, done_o}, 32'd0);
        txn(1'b0, 5'd1, 16'h0000, 16'h0000, "R10");
        chk(fail_o && !done_o, "R10", {30'd0, fail_o, done_o}, 32'd2);
        quiet(30, "R10");

        // reset bit stuck: poll budget expires
        pulse_start();
        txn(1'b1, 5'd0, 16'h8000, 16'h0000, "R1");
        for (int k = 0; k < PLIM; k++) begin
            chk(!fail_o, "R12", 32'(fail_o), 32'd0);
            txn(1'b0, 5'd0, 16'h0000, 16'h8000, "R12");
        end
        chk(fail_o && !done_o, "R12", {30'd0, fail_o, done_o}, 32'd2);
        quiet(40, "R12");

        summary();
        $finish;
    end
endmodule